// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block links two parallel buses, A and B, of parameterised width. Each direction has its own holding register with its own capture strobe. An output selector picks, for each direction, either the live value on the opposite bus or the value held in that direction's register. An active-low enable and a direction input decide which bus, if any, the block drives. Each bus is split into a separate input, output and output-enable, so the tri-state pads stay outside the block.

The two capture strobes are ordinary inputs sampled in the system clock domain. A capture happens in the cycle where a strobe is seen high after being low in the previous sample. Captures are never gated by the enable or the direction. This allows three modes of use. In isolation, both outputs are off and the registers still load. In store-and-forward, data captured earlier is replayed onto the other bus. In real-time mode, the live value is passed straight through with no register in the path.

Top module: `reg_bus_xcvr`

## Requirements
- R1: Synchronous reset (`rst` high) clears both registers to zero and forces `a_oe` and `b_oe` low. A strobe that is held high through reset does not cause a capture when reset is released.
- R2: When `cap_ab` is sampled 1 at a clock edge after being sampled 0 at the previous edge, the A register loads `a_in` at that edge.
- R3: When `cap_ba` is sampled 1 at a clock edge after being sampled 0 at the previous edge, the B register loads `b_in` at that edge.
- R4: Without such a 0-to-1 change, a register holds its value. This holds when a strobe stays high or falls, even while its bus input changes.
- R5: Capture is independent of `oe_n` and `dir`. It happens in isolation and while the captured bus is itself being driven, and it then stores the bus input port value.
- R6: While `oe_n` is 1, both `a_oe` and `b_oe` are 0.
- R7: While `oe_n` is 0 and `dir` is 0, `a_oe` is 1 and `b_oe` is 0. `a_out` equals `b_in` in the same cycle when `sel_ba` is 0, and equals the B register when `sel_ba` is 1. `sel_ab` has no effect on `a_out`.
- R8: While `oe_n` is 0 and `dir` is 1, `b_oe` is 1 and `a_oe` is 0. `b_out` equals `a_in` in the same cycle when `sel_ab` is 0, and equals the A register when `sel_ab` is 1.
- R9: `a_oe` and `b_oe` are never 1 at the same time.
- R10: Both registers can load on the same clock edge when both strobes rise together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 0: drive bus A, 1: drive bus B |
| cap_ab | input | 1 | Capture strobe for the A register |
| cap_ba | input | 1 | Capture strobe for the B register |
| sel_ab | input | 1 | B output source: 0 live A, 1 A register |
| sel_ba | input | 1 | A output source: 0 live B, 1 B register |
| a_in | input | W | Bus A input |
| a_out | output | W | Bus A output value |
| a_oe | output | 1 | Bus A output enable |
| b_in | input | W | Bus B input |
| b_out | output | W | Bus B output value |
| b_oe | output | 1 | Bus B output enable |

## Verification
The enables and the live path are purely combinational, so their results are checked shortly after the inputs change, with no clock edge in between. A capture lands at the same edge that first samples the rising strobe. Stored data is therefore checked at the falling edge that follows that single rising edge. The bench always drives inputs on falling edges and samples just before the next drive, so every register result is read exactly one edge after its stimulus.

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  logic [W-1:0] hold_a, hold_b;
  logic         ab_q, ba_q;
  logic         ab_rise, ba_rise;

  assign ab_rise = cap_ab & ~ab_q;
  assign ba_rise = cap_ba & ~ba_q;

  always_ff @(posedge clk) begin
    ab_q <= cap_ab;
    ba_q <= cap_ba;
    if (rst) begin
      hold_a <= '0;
      hold_b <= '0;
    end else begin
      if (ab_rise) hold_a <= a_in;
      if (ba_rise) hold_b <= b_in;
    end
  end

  assign a_oe  = ~rst & ~oe_n & ~dir;
  assign b_oe  = ~rst & ~oe_n &  dir;
  assign a_out = sel_ba ? hold_b : b_in;
  assign b_out = sel_ab ? hold_a : a_in;

  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (hold_a == '0 && hold_b == '0));

  a_r1_no_drive_in_reset: assert property (@(posedge clk)
    rst |-> (!a_oe && !b_oe));

  a_r2_capture_a: assert property (@(posedge clk) disable iff (rst)
    (cap_ab && !ab_q) |=> (hold_a == $past(a_in)));

  a_r3_capture_b: assert property (@(posedge clk) disable iff (rst)
    (cap_ba && !ba_q) |=> (hold_b == $past(b_in)));

  a_r4_hold_a: assert property (@(posedge clk) disable iff (rst)
    !(cap_ab && !ab_q) |=> $stable(hold_a));

  a_r4_hold_b: assert property (@(posedge clk) disable iff (rst)
    !(cap_ba && !ba_q) |=> $stable(hold_b));

  a_r6_isolation: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!a_oe && !b_oe));

  a_r7_live_b_to_a: assert property (@(posedge clk) disable iff (rst)
    (a_oe && !sel_ba) |-> (a_out == b_in));

  a_r8_live_a_to_b: assert property (@(posedge clk) disable iff (rst)
    (b_oe && !sel_ab) |-> (b_out == a_in));

  a_r9_single_driver: assert property (@(posedge clk)
    !(a_oe && b_oe));

endmodule

// File: tb/reg_bus_xcvr_tb_top.sv
`timescale 1ns/1ps
module reg_bus_xcvr_tb_top;
  localparam int W = 8;

  logic clk = 0, rst = 1, oe_n = 1, dir = 0;
  logic cap_ab = 0, cap_ba = 0, sel_ab = 0, sel_ba = 0;
  logic [W-1:0] a_in = '0, b_in = '0, a_out, b_out;
  logic a_oe, b_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  reg_bus_xcvr #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // {oe_n, dir, sel_ab, sel_ba, a_in, b_in, a_oe, b_oe, expected driven value}
  localparam logic [29:0] VEC [8] = '{
    {4'b1000, 8'h12, 8'h34, 2'b00, 8'h00},
    {4'b1111, 8'h12, 8'h34, 2'b00, 8'h00},
    {4'b0000, 8'h12, 8'h34, 2'b10, 8'h34},
    {4'b0010, 8'h56, 8'h78, 2'b10, 8'h78},
    {4'b0001, 8'h9A, 8'hBC, 2'b10, 8'h00},
    {4'b0100, 8'hDE, 8'hF0, 2'b01, 8'hDE},
    {4'b0101, 8'h21, 8'h43, 2'b01, 8'h21},
    {4'b0110, 8'h65, 8'h87, 2'b01, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R1: reset with strobes held high and enables requested
    @(negedge clk);
    rst = 1; oe_n = 0; dir = 1; cap_ab = 1; cap_ba = 1; a_in = 8'h5A; b_in = 8'hA5;
    tick();
    chk("R1 a_oe in reset", a_oe, 0);
    chk("R1 b_oe in reset", b_oe, 0);
    rst = 0;
    tick();
    tick();
    sel_ab = 1; sel_ba = 1; #1;
    chk("R1 A reg zero, no capture on held strobe", b_out, 8'h00);
    dir = 0; #1;
    chk("R1 B reg zero, no capture on held strobe", a_out, 8'h00);
    cap_ab = 0; cap_ba = 0;
    tick();

    // Table: control decoding with both registers still zero
    for (int i = 0; i < 8; i++) begin
      {oe_n, dir, sel_ab, sel_ba, a_in, b_in} = VEC[i][29:10];
      #1;
      chk(oe_n ? "R6 a_oe" : "R7 a_oe", a_oe, VEC[i][9]);
      chk(oe_n ? "R6 b_oe" : "R8 b_oe", b_oe, VEC[i][8]);
      chk("R9 single driver", a_oe & b_oe, 0);
      if (a_oe) chk("R7 a_out", a_out, VEC[i][7:0]);
      if (b_oe) chk("R8 b_out", b_out, VEC[i][7:0]);
      @(negedge clk);
    end

    // R2: capture A on rising strobe, replay to B
    oe_n = 0; dir = 1; sel_ab = 1; a_in = 8'h3C; cap_ab = 1;
    tick();
    chk("R2 A capture", b_out, 8'h3C);
    // R4: strobe held high, data changes
    a_in = 8'hFF;
    tick();
    chk("R4 hold while strobe high", b_out, 8'h3C);
    cap_ab = 0; a_in = 8'h11;
    tick();
    chk("R4 hold on strobe fall", b_out, 8'h3C);

    // R3: capture B, replay to A
    dir = 0; sel_ba = 1; b_in = 8'hC3; cap_ba = 1;
    tick();
    chk("R3 B capture", a_out, 8'hC3);
    cap_ba = 0;
    tick();

    // R10 + R5: both captured together in isolation
    oe_n = 1; a_in = 8'hA1; b_in = 8'hB2; cap_ab = 1; cap_ba = 1;
    tick();
    chk("R6 isolation a_oe", a_oe, 0);
    chk("R6 isolation b_oe", b_oe, 0);
    cap_ab = 0; cap_ba = 0; a_in = 8'h00; b_in = 8'h00;
    tick();
    oe_n = 0; dir = 1; sel_ab = 1; #1;
    chk("R10 A loaded in joint capture", b_out, 8'hA1);
    dir = 0; sel_ba = 1; #1;
    chk("R10 B loaded in joint capture", a_out, 8'hB2);

    // R5: capture the bus that is being driven (A driven, dir=0)
    a_in = 8'h77; cap_ab = 1;
    tick();
    chk("R5 a_oe while capturing A", a_oe, 1);
    cap_ab = 0; a_in = 8'h00;
    tick();
    dir = 1; sel_ab = 1; #1;
    chk("R5 captured port value of driven bus", b_out, 8'h77);

    // R8: live path follows a_in combinationally
    sel_ab = 0; a_in = 8'h4D; #1;
    chk("R8 live A to B", b_out, 8'h4D);
    // R7: sel_ab has no effect on A output
    dir = 0; sel_ba = 0; sel_ab = 1; b_in = 8'h9E; #1;
    chk("R7 live B to A ignoring sel_ab", a_out, 8'h9E);

    done = 1;
    finish_run();
  end
endmodule